// File: doc/BRIEF.md
# Code-Density Bin Calibrator for a Delay-Line Time Digitizer

This block turns the raw fine-time code of a delay-line time digitizer into a time in picoseconds. The delay taps of such a line have unequal widths. If hits arrive evenly spread over the clock period, the number of hits that fall in a bin is proportional to that bin's width. The block books every valid hit into a per-bin counter memory, using a read-increment-write pipeline that takes one hit per clock. Once a fixed batch of hits has been booked, it sweeps the counters and builds a new conversion table from the running sum of the counts.

The table has two banks. Live hits are always converted through the active bank while the rebuild writes the other one, and the two banks swap when the sweep ends. The sweep also clears each counter it reads, so every batch starts from an empty histogram and the calibration refreshes without stopping. Each calibrated output is a table lookup registered one cycle after the raw code, and it carries the input valid flag with it.

Top module: `tdc_bin_calib`

## Requirements
- R1: After reset and before the first rebuild, bin i converts to floor((2i+1)·PERIOD_PS / (2·NBINS)). With the defaults (64 bins, 4000 ps) this is floor((2i+1)·31.25).
- R2: `cal_valid` equals `raw_valid` of the previous cycle. `cal_ps` is the active table's entry for the `raw_code` of the previous cycle, whether or not that cycle's hit was valid.
- R3: Each accepted valid hit adds exactly one to the counter of its bin, at a rate of one hit per clock. The stream must not present the same bin again within 4 cycles. A bin counter never wraps within a batch.
- R4: A rebuild starts after exactly 2^EV_LOG2 accepted hits (16384 by default). The new entry for bin i is floor((2·B_i + C_i)·PERIOD_PS / 2^(EV_LOG2+1)), where C_i is the bin's count and B_i is the sum of the counts of all lower bins. This is the width of the lower bins plus half the bin's own width, with each width equal to count·PERIOD_PS/2^EV_LOG2.
- R5: While a rebuild is in progress, lookups keep using the previous table. The new table takes effect only once every bin has been rewritten.
- R6: Every counter is zero once a rebuild ends, so the next table reflects only the hits of the next batch.
- R7: Valid hits presented while a rebuild is in progress are neither booked nor counted toward the next batch.
- R8: A bin that received no hits in a batch converts to exactly the cumulative time of the bins below it. Across the table, entries never decrease with bin number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_code | input | CODE_W | Raw fine-time bin of the incoming hit |
| raw_valid | input | 1 | Marks `raw_code` as a real hit |
| cal_ps | output | TIME_W | Calibrated time in picoseconds |
| cal_valid | output | 1 | Valid flag delayed along with `cal_ps` |

## Verification
The bench targets the swap point. It converts a bin immediately after the batch-closing hit and expects the old table; a design that swapped banks at the start of the sweep would return half-built values there. A burst of hits sent during the sweep must leave no trace in the next table; a design that kept booking them would move every entry above the affected bins and end its next batch early. A second batch that fills only even bins checks two things: that the histogram was cleared, which stale counts would show as wrong entries everywhere, and that empty bins sit exactly at the cumulative time of the bins below them, where an off-by-one in the half-width term would misplace them.

// File: rtl/tdccal_pkg.sv
package tdccal_pkg;

    typedef enum logic [1:0] {
        BLD_IDLE  = 2'd0,
        BLD_DRAIN = 2'd1,
        BLD_SWEEP = 2'd2
    } bld_state_t;

    // Centre of bin i when all bins are assumed equal.
    function automatic longint unsigned ideal_time(
        longint unsigned idx,
        longint unsigned nbins,
        longint unsigned period
    );
        return ((2 * idx + 1) * period) / (2 * nbins);
    endfunction

    // Lower-bin cumulative width plus half the own width, scaled to picoseconds.
    function automatic longint unsigned scaled_time(
        longint unsigned below,
        longint unsigned cnt,
        longint unsigned period,
        int unsigned     ev_log2
    );
        return ((2 * below + cnt) * period) >> (ev_log2 + 1);
    endfunction

endpackage

// File: rtl/tdccal_hist.sv
module tdccal_hist #(
    parameter int unsigned CODE_W  = 6,
    parameter int unsigned EV_LOG2 = 14,
    parameter int unsigned CNT_W   = EV_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] hit_code,
    input  logic              hit_valid,
    input  logic              busy,
    output logic              batch_done,
    input  logic              sw_en,
    input  logic [CODE_W-1:0] sw_idx,
    output logic [CNT_W-1:0]  sw_count
);
    localparam int unsigned NBINS = 1 << CODE_W;

    typedef struct packed {
        logic              v;
        logic [CODE_W-1:0] code;
    } stage_t;

    logic [CNT_W-1:0]   hist [NBINS];
    logic [EV_LOG2-1:0] ev_cnt;
    stage_t             s1, s2;
    logic [CNT_W-1:0]   s2_rd;
    logic               accept;

    assign accept     = hit_valid && !busy;
    assign batch_done = accept && (ev_cnt == '1);
    assign sw_count   = hist[sw_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_cnt <= '0;
            s1     <= '0;
            s2     <= '0;
            s2_rd  <= '0;
            for (int i = 0; i < NBINS; i++) begin
                hist[i] <= '0;
            end
        end else begin
            if (accept) begin
                ev_cnt <= ev_cnt + 1'b1;
            end
            s1.v    <= accept;
            s1.code <= hit_code;
            s2      <= s1;
            s2_rd   <= hist[s1.code];
            if (sw_en) begin
                hist[sw_idx] <= '0;
            end else if (s2.v) begin
                hist[s2.code] <= s2_rd + 1'b1;
            end
        end
    end

    // Input contract: the read of a bin must not race its own pending write-back.
    assert_same_bin_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (s1.v && s2.v) |-> (s1.code != s2.code));

    // A counter must never be incremented from its maximum value.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        s2.v |-> (s2_rd != '1));

endmodule

// File: rtl/tdccal_build.sv
module tdccal_build
    import tdccal_pkg::*;
#(
    parameter int unsigned CODE_W    = 6,
    parameter int unsigned EV_LOG2   = 14,
    parameter int unsigned CNT_W     = EV_LOG2 + 1,
    parameter int unsigned TIME_W    = 12,
    parameter int unsigned PERIOD_PS = 4000,
    parameter int unsigned DRAIN     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              batch_done,
    output logic              busy,
    output logic              sw_en,
    output logic [CODE_W-1:0] sw_idx,
    input  logic [CNT_W-1:0]  sw_count,
    output logic              tw_en,
    output logic [CODE_W-1:0] tw_idx,
    output logic [TIME_W-1:0] tw_time,
    output logic              swap
);
    localparam int unsigned DR_W   = $clog2(DRAIN + 1);
    localparam int unsigned EVENTS = 1 << EV_LOG2;

    bld_state_t        state;
    logic [DR_W-1:0]   dcnt;
    logic [CODE_W-1:0] idx;
    logic [CNT_W-1:0]  cum;
    logic [TIME_W-1:0] prev_time;
    logic              last_bin;

    assign busy     = (state != BLD_IDLE);
    assign sw_en    = (state == BLD_SWEEP);
    assign tw_en    = sw_en;
    assign sw_idx   = idx;
    assign tw_idx   = idx;
    assign last_bin = (idx == '1);
    assign swap     = sw_en && last_bin;
    assign tw_time  = TIME_W'(scaled_time(64'(cum), 64'(sw_count),
                                          64'(PERIOD_PS), EV_LOG2));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= BLD_IDLE;
            dcnt      <= '0;
            idx       <= '0;
            cum       <= '0;
            prev_time <= '0;
        end else begin
            unique case (state)
                BLD_IDLE: begin
                    if (batch_done) begin
                        state <= BLD_DRAIN;
                        dcnt  <= '0;
                    end
                end
                BLD_DRAIN: begin
                    dcnt <= dcnt + 1'b1;
                    if (dcnt == DR_W'(DRAIN - 1)) begin
                        state <= BLD_SWEEP;
                        idx   <= '0;
                        cum   <= '0;
                    end
                end
                BLD_SWEEP: begin
                    cum       <= cum + sw_count;
                    idx       <= idx + 1'b1;
                    prev_time <= tw_time;
                    if (last_bin) begin
                        state <= BLD_IDLE;
                    end
                end
                default: state <= BLD_IDLE;
            endcase
        end
    end

    // Entries written during one sweep never go down.
    assert_table_monotonic_R8: assert property (@(posedge clk) disable iff (rst)
        (sw_en && idx != '0) |-> (tw_time >= prev_time));

    // The booked counts of one batch add up to exactly the batch size.
    assert_batch_total_R4: assert property (@(posedge clk) disable iff (rst)
        swap |-> ((cum + sw_count) == CNT_W'(EVENTS)));

endmodule

// File: rtl/tdccal_lut.sv
module tdccal_lut
    import tdccal_pkg::*;
#(
    parameter int unsigned CODE_W    = 6,
    parameter int unsigned TIME_W    = 12,
    parameter int unsigned PERIOD_PS = 4000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tw_en,
    input  logic [CODE_W-1:0] tw_idx,
    input  logic [TIME_W-1:0] tw_time,
    input  logic              swap,
    input  logic [CODE_W-1:0] look_code,
    input  logic              look_valid,
    output logic [TIME_W-1:0] out_time,
    output logic              out_valid
);
    localparam int unsigned NBINS = 1 << CODE_W;

    logic [TIME_W-1:0] bank [2][NBINS];
    logic              act;

    always_ff @(posedge clk) begin
        if (rst) begin
            act       <= 1'b0;
            out_time  <= '0;
            out_valid <= 1'b0;
            for (int i = 0; i < NBINS; i++) begin
                bank[0][i] <= TIME_W'(ideal_time(64'(i), 64'(NBINS), 64'(PERIOD_PS)));
                bank[1][i] <= TIME_W'(ideal_time(64'(i), 64'(NBINS), 64'(PERIOD_PS)));
            end
        end else begin
            if (tw_en) begin
                bank[!act][tw_idx] <= tw_time;
            end
            if (swap) begin
                act <= !act;
            end
            out_valid <= look_valid;
            out_time  <= bank[act][look_code];
        end
    end

endmodule

// File: rtl/tdc_bin_calib.sv
module tdc_bin_calib #(
    parameter int unsigned CODE_W    = 6,
    parameter int unsigned EV_LOG2   = 14,
    parameter int unsigned PERIOD_PS = 4000,
    parameter int unsigned TIME_W    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] raw_code,
    input  logic              raw_valid,
    output logic [TIME_W-1:0] cal_ps,
    output logic              cal_valid
);
    localparam int unsigned CNT_W = EV_LOG2 + 1;
    localparam int unsigned DRAIN = 3;

    logic              busy, batch_done, sw_en, tw_en, swap;
    logic [CODE_W-1:0] sw_idx, tw_idx;
    logic [CNT_W-1:0]  sw_count;
    logic [TIME_W-1:0] tw_time;

    tdccal_hist #(
        .CODE_W (CODE_W),
        .EV_LOG2(EV_LOG2),
        .CNT_W  (CNT_W)
    ) u_hist (
        .clk       (clk),
        .rst       (rst),
        .hit_code  (raw_code),
        .hit_valid (raw_valid),
        .busy      (busy),
        .batch_done(batch_done),
        .sw_en     (sw_en),
        .sw_idx    (sw_idx),
        .sw_count  (sw_count)
    );

    tdccal_build #(
        .CODE_W   (CODE_W),
        .EV_LOG2  (EV_LOG2),
        .CNT_W    (CNT_W),
        .TIME_W   (TIME_W),
        .PERIOD_PS(PERIOD_PS),
        .DRAIN    (DRAIN)
    ) u_build (
        .clk       (clk),
        .rst       (rst),
        .batch_done(batch_done),
        .busy      (busy),
        .sw_en     (sw_en),
        .sw_idx    (sw_idx),
        .sw_count  (sw_count),
        .tw_en     (tw_en),
        .tw_idx    (tw_idx),
        .tw_time   (tw_time),
        .swap      (swap)
    );

    tdccal_lut #(
        .CODE_W   (CODE_W),
        .TIME_W   (TIME_W),
        .PERIOD_PS(PERIOD_PS)
    ) u_lut (
        .clk       (clk),
        .rst       (rst),
        .tw_en     (tw_en),
        .tw_idx    (tw_idx),
        .tw_time   (tw_time),
        .swap      (swap),
        .look_code (raw_code),
        .look_valid(raw_valid),
        .out_time  (cal_ps),
        .out_valid (cal_valid)
    );

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        raw_valid |=> cal_valid);

    assert_invalid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        !raw_valid |=> !cal_valid);

endmodule

// File: tb/sim_tdc_bin_calib.sv
module sim_tdc_bin_calib;
    localparam int CLK_PERIOD = 10;
    localparam int NB         = 64;
    localparam int EVN        = 16384;
    localparam int PER        = 4000;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  raw_code = '0;
    logic        raw_valid = 1'b0;
    logic [11:0] cal_ps;
    logic        cal_valid;

    int checks = 0;
    int failures = 0;
    int hist [NB];
    int tab  [NB];

    tdc_bin_calib u0 (
        .clk      (clk),
        .rst      (rst),
        .raw_code (raw_code),
        .raw_valid(raw_valid),
        .cal_ps   (cal_ps),
        .cal_valid(cal_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void rebuild_model();
        longint below = 0;
        for (int b = 0; b < NB; b++) begin
            tab[b] = int'(((2 * below + longint'(hist[b])) * PER) >> 15);
            below += hist[b];
        end
        for (int b = 0; b < NB; b++) hist[b] = 0;
    endfunction

    task automatic check_table(input string req_even, input string req_odd);
        for (int b = 0; b < NB; b++) begin
            raw_code  = 6'(b);
            raw_valid = 1'b0;
            @(negedge clk);
            chk((b % 2 == 0) ? req_even : req_odd, int'(cal_ps), tab[b],
                $sformatf("bin %0d time", b));
        end
    endtask

    // mode 0: biased random with idle gaps; mode 1: even bins only, cyclic.
    task automatic send_batch(input int mode);
        int cnt = 0;
        int k = 0;
        int l0 = -1, l1 = -1, l2 = -1;
        int pc = 0, pv = 0;
        bit have = 0;
        while (cnt < EVN) begin
            @(negedge clk);
            if (have) begin
                chk("R2", int'(cal_valid), pv, "valid delay");
                chk("R2", int'(cal_ps), tab[pc], "lookup delay");
            end
            if (mode == 0 && ($urandom % 8) == 0) begin
                pc = int'($urandom % NB);
                pv = 0;
            end else begin
                int c;
                if (mode == 0) begin
                    do begin
                        c = (($urandom % 4) == 0) ? int'($urandom % 8) : int'($urandom % NB);
                    end while (c == l0 || c == l1 || c == l2);
                end else begin
                    c = (k % 32) * 2;
                    k++;
                end
                l2 = l1; l1 = l0; l0 = c;
                pc = c;
                pv = 1;
                hist[c]++;   // R3: one count per accepted hit
                cnt++;
            end
            raw_code  = 6'(pc);
            raw_valid = pv[0];
            have = 1;
        end
        @(negedge clk);
        chk("R2", int'(cal_valid), pv, "valid delay");
        chk("R2", int'(cal_ps), tab[pc], "lookup delay");
        // R5: right after the batch closes the old table must still be in use
        raw_code  = 6'd5;
        raw_valid = 1'b0;
        @(negedge clk);
        chk("R5", int'(cal_ps), tab[5], "old table during rebuild");
        // R7: hits inside the rebuild window, left out of the model
        for (int j = 0; j < 16; j++) begin
            raw_code  = 6'(56 + (j % 8));
            raw_valid = 1'b1;
            @(negedge clk);
            chk("R5", int'(cal_ps), tab[56 + (j % 8)], "old table during rebuild");
        end
        raw_valid = 1'b0;
        repeat (150) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
        finish_run();
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        for (int b = 0; b < NB; b++) begin
            hist[b] = 0;
            tab[b]  = ((2 * b + 1) * PER) / (2 * NB);
        end
        repeat (4) @(negedge clk);
        chk("R2", int'(cal_valid), 0, "valid in reset");
        rst = 1'b0;
        @(negedge clk);

        check_table("R1", "R1");        // ideal table after reset

        send_batch(0);                  // R3 R4 R7: random batch plus ignored burst
        rebuild_model();
        check_table("R4 R7", "R4 R7");

        send_batch(1);                  // R6 R8: histogram cleared, empty odd bins
        rebuild_model();
        check_table("R6", "R8");
        for (int b = 1; b < NB; b++) begin
            chk("R8", int'(tab[b] >= tab[b-1]), 1, $sformatf("monotonic at bin %0d", b));
        end

        finish_run();
    end

endmodule